// File: doc/BRIEF.md
# Backlight Brightness Source Selector

This block lives inside a panel timing controller and decides the brightness and the PWM frequency of the panel backlight. It has three brightness sources:

- a fixed level set by a parameter;
- the duty cycle it measures on an incoming PWM pin;
- a level written by the host over a simple register port.

A two-bit mode register picks one of these sources, or the product of the pin duty and the written level. Read-only capability inputs, tied off by the panel integration, decide which modes and which frequency sources the host may use.

The block drives four outputs: a selected duty, a selected PWM period (in clock cycles), an enable, and a PWM waveform built from these. The frequency source is chosen apart from the brightness source. It is one of three: a preset period, the period measured on the pin, or a period written over the register port. The enable comes from a dedicated pin or from a control register bit. The register port is write-only and takes one write per cycle: an enable strobe, a 12-bit address and a data word.

Top module: `bl_src_sel`

## Requirements
- R1: After reset, bl_duty equals the preset duty (default 0x8000), bl_period equals the preset period (default 200), and bl_enable and bl_pwm are low.
- R2: Mode value 00 selects the measured pin duty. For a pin that is high for H clocks out of each P-clock period, this is floor(H*65536/P). It is refreshed once per pin period, on the rising edge.
- R3: Mode value 01 selects the preset duty.
- R4: Mode value 10 selects the 16-bit level register at address 0x041.
- R5: Mode value 11 selects (measured pin duty * level register) >> 16.
- R6: The mode is written at address 0x040, data bits [1:0]. A write is accepted only when cap_mode[value] is 1; otherwise the stored mode is unchanged.
- R7: If the capability bit of the stored mode is 0, the preset duty is used.
- R8: Frequency select register 0x042: bit1 enables the register period at 0x043, and bit0 enables pin pass-through. The register period is used when bit1 and cap_reg_freq are both set and the value is at least 2. It takes priority over pass-through.
- R9: Pass-through sets bl_period to the measured pin period, in clocks. It applies when bit0 and cap_pin_freq are both set and a valid pin measurement exists. When neither the register period nor pass-through applies, the preset period is used.
- R10: bl_enable is the OR of the pin bl_en_pin and bit0 of the control register at address 0x01A.
- R11: While bl_enable is low, bl_pwm is low. While it is high, bl_pwm is high for floor(bl_duty*bl_period/65536) clocks in every bl_period clocks.
- R12: If the pin has no edge for the number of clocks held in the timeout register at 0x044, the measured duty becomes 0 and the pin frequency is invalid. The next pin period after activity resumes restores the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write address |
| wr_data | input | W | Register write data |
| cap_mode | input | 4 | Capability per brightness mode, indexed by mode value |
| cap_pin_freq | input | 1 | Capability for pin frequency pass-through |
| cap_reg_freq | input | 1 | Capability for register-set frequency |
| bl_en_pin | input | 1 | Dedicated backlight enable pin |
| pwm_in | input | 1 | External PWM input (asynchronous) |
| bl_enable | output | 1 | Backlight enable |
| bl_duty | output | W | Selected duty, full scale 2^W |
| bl_period | output | W | Selected PWM period in clocks |
| bl_pwm | output | 1 | Backlight PWM waveform |

## Verification
Two internal faults show up one clock after the stored mode or frequency select settles:

- a stored mode that disagrees with the capability inputs puts a wrong value on bl_duty;
- a wrong frequency priority puts a wrong value on bl_period.

A fault in the pin meter's counters or divider shows as a wrong bl_duty in mode 00 about one pin period plus 17 clocks after the pin changes its pattern. A fault in the timeout logic shows as a non-zero duty once the stated number of idle clocks has passed. A fault in the output generator shows as a wrong count of high clocks over two output periods, or as any high clock while disabled.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int AW = 12;

  typedef enum logic [1:0] {
    BM_PIN    = 2'b00,
    BM_PRESET = 2'b01,
    BM_LEVEL  = 2'b10,
    BM_PROD   = 2'b11
  } bmode_t;

  localparam logic [AW-1:0] A_CTRL  = 12'h01A;
  localparam logic [AW-1:0] A_MODE  = 12'h040;
  localparam logic [AW-1:0] A_LEVEL = 12'h041;
  localparam logic [AW-1:0] A_FSEL  = 12'h042;
  localparam logic [AW-1:0] A_FPER  = 12'h043;
  localparam logic [AW-1:0] A_TOUT  = 12'h044;
endpackage

// File: rtl/bl_regs.sv
module bl_regs
  import bl_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] RST_PERIOD = 16'd200,
  parameter logic [W-1:0] RST_TOUT = 16'd4000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [3:0]    cap_mode,
  output logic          ctrl_on,
  output bmode_t        mode,
  output logic [W-1:0]  level,
  output logic [1:0]    fsel,
  output logic [W-1:0]  fper,
  output logic [W-1:0]  tout
);
  logic         ctrl_q, ctrl_d;
  bmode_t       mode_q, mode_d;
  logic [W-1:0] level_q, level_d;
  logic [1:0]   fsel_q, fsel_d;
  logic [W-1:0] fper_q, fper_d;
  logic [W-1:0] tout_q, tout_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    mode_d  = mode_q;
    level_d = level_q;
    fsel_d  = fsel_q;
    fper_d  = fper_q;
    tout_d  = tout_q;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl_d = wr_data[0];
        A_MODE:  if (cap_mode[wr_data[1:0]]) mode_d = bmode_t'(wr_data[1:0]);
        A_LEVEL: level_d = wr_data;
        A_FSEL:  fsel_d = wr_data[1:0];
        A_FPER:  fper_d = wr_data;
        A_TOUT:  tout_d = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= 1'b0;
      mode_q  <= BM_PRESET;
      level_q <= '0;
      fsel_q  <= '0;
      fper_q  <= RST_PERIOD;
      tout_q  <= RST_TOUT;
    end else begin
      ctrl_q  <= ctrl_d;
      mode_q  <= mode_d;
      level_q <= level_d;
      fsel_q  <= fsel_d;
      fper_q  <= fper_d;
      tout_q  <= tout_d;
    end
  end

  assign ctrl_on = ctrl_q;
  assign mode    = mode_q;
  assign level   = level_q;
  assign fsel    = fsel_q;
  assign fper    = fper_q;
  assign tout    = tout_q;

  // a change of the stored mode only ever lands on a capable mode
  assert_mode_capable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> cap_mode[mode_q]);
endmodule

// File: rtl/bl_pin_meter.sv
module bl_pin_meter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_raw,
  input  logic [W-1:0] tout,
  output logic [W-1:0] duty,
  output logic [W-1:0] period,
  output logic         valid
);
  localparam int SW = $clog2(W + 1);
  localparam logic [W-1:0] MAXV = '1;

  logic s1_q, s2_q, s3_q;
  logic rise, edg, stale;
  logic [W-1:0] per_q, per_d, hi_q, hi_d, idle_q, idle_d, per_p1;
  logic armed_q, armed_d;
  logic busy_q, busy_d;
  logic [SW-1:0] step_q, step_d;
  logic [W:0] rem_q, rem_d, rem2;
  logic [W-1:0] quo_q, quo_d, dvs_q, dvs_d;
  logic [W-1:0] duty_q, duty_d, mper_q, mper_d;
  logic valid_q, valid_d;
  logic ge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_raw;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb begin
    rise   = s2_q & ~s3_q;
    edg    = s2_q ^ s3_q;
    stale  = (idle_q >= tout);
    per_p1 = (per_q == MAXV) ? MAXV : per_q + 1'b1;
    idle_d = edg ? '0 : ((idle_q == MAXV) ? idle_q : idle_q + 1'b1);
    per_d  = rise ? '0 : per_p1;
    if (rise)                      hi_d = {{(W-1){1'b0}}, 1'b1};
    else if (s2_q && hi_q != MAXV) hi_d = hi_q + 1'b1;
    else                           hi_d = hi_q;
    armed_d = rise ? 1'b1 : (stale ? 1'b0 : armed_q);

    rem2    = {rem_q[W-1:0], 1'b0};
    ge      = (rem2 >= {1'b0, dvs_q});
    busy_d  = busy_q;
    step_d  = step_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    dvs_d   = dvs_q;
    duty_d  = duty_q;
    mper_d  = mper_q;
    valid_d = valid_q;

    if (stale) begin
      duty_d  = '0;
      valid_d = 1'b0;
      busy_d  = 1'b0;
    end else if (rise && armed_q && !busy_q) begin
      mper_d  = per_p1;
      valid_d = 1'b1;
      if (hi_q >= per_p1) begin
        duty_d = MAXV;
      end else begin
        busy_d = 1'b1;
        step_d = SW'(W);
        rem_d  = {1'b0, hi_q};
        quo_d  = '0;
        dvs_d  = per_p1;
      end
    end else if (busy_q) begin
      rem_d  = ge ? (rem2 - {1'b0, dvs_q}) : rem2;
      quo_d  = {quo_q[W-2:0], ge};
      step_d = step_q - 1'b1;
      if (step_q == SW'(1)) begin
        busy_d = 1'b0;
        duty_d = quo_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q   <= '0;
      hi_q    <= '0;
      idle_q  <= '0;
      armed_q <= 1'b0;
      busy_q  <= 1'b0;
      step_q  <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      duty_q  <= '0;
      mper_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      per_q   <= per_d;
      hi_q    <= hi_d;
      idle_q  <= idle_d;
      armed_q <= armed_d;
      busy_q  <= busy_d;
      step_q  <= step_d;
      rem_q   <= rem_d;
      quo_q   <= quo_d;
      dvs_q   <= dvs_d;
      duty_q  <= duty_d;
      mper_q  <= mper_d;
      valid_q <= valid_d;
    end
  end

  assign duty   = duty_q;
  assign period = mper_q;
  assign valid  = valid_q;

  // an idle pin beyond the timeout clears the measured duty and validity
  assert_stale_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stale |=> (duty_q == '0 && !valid_q));
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_PERIOD = 16'd200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] duty,
  input  logic [W-1:0] period,
  output logic         pwm
);
  logic [W-1:0]   cnt_q, cnt_d, perl_q, perl_d, thr_q, thr_d;
  logic [2*W-1:0] prod;
  logic           wrap;
  logic           pwm_q, pwm_d;

  always_comb begin
    prod   = {{W{1'b0}}, duty} * {{W{1'b0}}, period};
    wrap   = (cnt_q >= perl_q - 1'b1);
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    perl_d = wrap ? period : perl_q;
    thr_d  = wrap ? prod[2*W-1:W] : thr_q;
    pwm_d  = en && (cnt_q < thr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      perl_q <= RST_PERIOD;
      thr_q  <= '0;
      pwm_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      perl_q <= perl_d;
      thr_q  <= thr_d;
      pwm_q  <= pwm_d;
    end
  end

  assign pwm = pwm_q;

  assert_pwm_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_q);
endmodule

// File: rtl/bl_src_sel.sv
module bl_src_sel
  import bl_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] PRESET_DUTY = 16'h8000,
  parameter logic [W-1:0] PRESET_PERIOD = 16'd200,
  parameter logic [W-1:0] TOUT_DEF = 16'd4000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [11:0]  wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [3:0]   cap_mode,
  input  logic         cap_pin_freq,
  input  logic         cap_reg_freq,
  input  logic         bl_en_pin,
  input  logic         pwm_in,
  output logic         bl_enable,
  output logic [W-1:0] bl_duty,
  output logic [W-1:0] bl_period,
  output logic         bl_pwm
);
  logic           ctrl_on;
  bmode_t         mode, mode_eff;
  logic [W-1:0]   level, fper, tout;
  logic [1:0]     fsel;
  logic [W-1:0]   m_duty, m_period;
  logic           m_valid;
  logic [2*W-1:0] mix;
  logic [W-1:0]   duty_q, duty_d, per_q, per_d;
  logic           en_q, en_d;

  bl_regs #(.W(W), .RST_PERIOD(PRESET_PERIOD), .RST_TOUT(TOUT_DEF)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cap_mode(cap_mode), .ctrl_on(ctrl_on), .mode(mode),
    .level(level), .fsel(fsel), .fper(fper), .tout(tout)
  );

  bl_pin_meter #(.W(W)) u_meter (
    .clk(clk), .rst_n(rst_n), .pin_raw(pwm_in), .tout(tout),
    .duty(m_duty), .period(m_period), .valid(m_valid)
  );

  always_comb begin
    mode_eff = cap_mode[mode] ? mode : BM_PRESET;
    mix      = {{W{1'b0}}, m_duty} * {{W{1'b0}}, level};
    case (mode_eff)
      BM_PIN:   duty_d = m_duty;
      BM_LEVEL: duty_d = level;
      BM_PROD:  duty_d = mix[2*W-1:W];
      default:  duty_d = PRESET_DUTY;
    endcase
    if (fsel[1] && cap_reg_freq && fper >= W'(2))
      per_d = fper;
    else if (fsel[0] && cap_pin_freq && m_valid && m_period >= W'(2))
      per_d = m_period;
    else
      per_d = PRESET_PERIOD;
    en_d = bl_en_pin | ctrl_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= PRESET_DUTY;
      per_q  <= PRESET_PERIOD;
      en_q   <= 1'b0;
    end else begin
      duty_q <= duty_d;
      per_q  <= per_d;
      en_q   <= en_d;
    end
  end

  bl_pwm_gen #(.W(W), .RST_PERIOD(PRESET_PERIOD)) u_pwm (
    .clk(clk), .rst_n(rst_n), .en(en_q), .duty(duty_q), .period(per_q),
    .pwm(bl_pwm)
  );

  assign bl_enable = en_q;
  assign bl_duty   = duty_q;
  assign bl_period = per_q;

  assert_period_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bl_period >= W'(2));
  assert_preset_duty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == BM_PRESET) |=> (bl_duty == PRESET_DUTY));
endmodule

// File: tb/sim_bl_src_sel.sv
module sim_bl_src_sel;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [3:0] cap_mode = 4'hF;
  logic cap_pin_freq = 1'b1;
  logic cap_reg_freq = 1'b1;
  logic bl_en_pin = 1'b0;
  logic pwm_in = 1'b0;
  logic bl_enable, bl_pwm;
  logic [W-1:0] bl_duty, bl_period;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit pin_run = 0;
  int pin_h = 30;
  int pin_l = 70;

  always #(CLK_PERIOD/2) clk = ~clk;

  bl_src_sel u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cap_mode(cap_mode), .cap_pin_freq(cap_pin_freq),
    .cap_reg_freq(cap_reg_freq), .bl_en_pin(bl_en_pin), .pwm_in(pwm_in),
    .bl_enable(bl_enable), .bl_duty(bl_duty), .bl_period(bl_period),
    .bl_pwm(bl_pwm)
  );

  // pin stimulus, changed on falling edges
  always begin
    @(negedge clk);
    if (pin_run) begin
      pwm_in = 1'b1;
      repeat (pin_h) @(negedge clk);
      pwm_in = 1'b0;
      repeat (pin_l - 1) @(negedge clk);
    end else begin
      pwm_in = 1'b0;
    end
  end

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic longint pin_duty(input int h, input int l);
    return (longint'(h) * 65536) / (h + l);
  endfunction

  task automatic t_reset();
    chk("R1 duty", bl_duty, 16'h8000);
    chk("R1 period", bl_period, 200);
    chk("R1 enable", bl_enable, 0);
    chk("R1 pwm", bl_pwm, 0);
  endtask

  task automatic t_level();
    wr(12'h041, 16'h1234);
    wr(12'h040, 16'h0002);
    chk("R4 level mode", bl_duty, 16'h1234);
    wr(12'h040, 16'h0001);
    chk("R3 preset mode", bl_duty, 16'h8000);
  endtask

  task automatic t_pin();
    pin_h = 30; pin_l = 70; pin_run = 1;
    wr(12'h040, 16'h0000);
    repeat (500) @(negedge clk);
    chk("R2 pin 30/100", bl_duty, pin_duty(30, 70));
    chk("R9 no passthrough", bl_period, 200);
    pin_h = 75; pin_l = 25;
    repeat (500) @(negedge clk);
    chk("R2 pin 75/100", bl_duty, pin_duty(75, 25));
  endtask

  task automatic t_prod();
    wr(12'h041, 16'h8000);
    wr(12'h040, 16'h0003);
    chk("R5 product", bl_duty, (pin_duty(75, 25) * 32768) >> 16);
    wr(12'h041, 16'hFFFF);
    chk("R5 product full", bl_duty, (pin_duty(75, 25) * 65535) >> 16);
  endtask

  task automatic t_freq();
    wr(12'h042, 16'h0001);
    chk("R9 passthrough", bl_period, 100);
    cap_pin_freq = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 no capability", bl_period, 200);
    cap_pin_freq = 1'b1;
    wr(12'h043, 16'd500);
    wr(12'h042, 16'h0003);
    chk("R8 register wins", bl_period, 500);
    wr(12'h043, 16'd1);
    chk("R8 too small", bl_period, 100);
    wr(12'h043, 16'd300);
    cap_reg_freq = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 no capability", bl_period, 100);
    cap_reg_freq = 1'b1;
    wr(12'h042, 16'h0000);
    chk("R9 preset", bl_period, 200);
  endtask

  task automatic t_caps();
    wr(12'h041, 16'h2222);
    wr(12'h040, 16'h0002);
    cap_mode = 4'b0111;
    wr(12'h040, 16'h0003);
    chk("R6 write ignored", bl_duty, 16'h2222);
    cap_mode = 4'b0011;
    repeat (3) @(negedge clk);
    chk("R7 capability dropped", bl_duty, 16'h8000);
    cap_mode = 4'hF;
    repeat (3) @(negedge clk);
    chk("R7 capability back", bl_duty, 16'h2222);
  endtask

  task automatic count_high(output int n, input int cycles);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (bl_pwm) n++;
    end
  endtask

  task automatic t_enable();
    int n;
    wr(12'h041, 16'h4000);
    wr(12'h040, 16'h0002);
    repeat (450) @(negedge clk);
    count_high(n, 400);
    chk("R11 off high count", n, 0);
    chk("R10 off", bl_enable, 0);
    wr(12'h01A, 16'h0001);
    chk("R10 register on", bl_enable, 1);
    repeat (450) @(negedge clk);
    count_high(n, 400);
    chk("R11 on high count", n, 100);
    wr(12'h01A, 16'h0000);
    chk("R10 register off", bl_enable, 0);
    bl_en_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 pin on", bl_enable, 1);
    bl_en_pin = 1'b0;
    repeat (3) @(negedge clk);
    count_high(n, 400);
    chk("R11 off again", n, 0);
  endtask

  task automatic t_timeout();
    wr(12'h044, 16'd300);
    wr(12'h042, 16'h0001);
    wr(12'h040, 16'h0000);
    pin_h = 40; pin_l = 60;
    repeat (400) @(negedge clk);
    chk("R2 before timeout", bl_duty, pin_duty(40, 60));
    chk("R9 before timeout", bl_period, 100);
    pin_run = 0;
    repeat (600) @(negedge clk);
    chk("R12 duty zero", bl_duty, 0);
    chk("R12 preset period", bl_period, 200);
    pin_h = 20; pin_l = 60; pin_run = 1;
    repeat (400) @(negedge clk);
    chk("R12 recovered", bl_duty, pin_duty(20, 60));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_level();
    t_pin();
    t_prod();
    t_freq();
    t_caps();
    t_enable();
    t_timeout();
    finish_run();
  end
endmodule